// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two external-bus strobes of an 8-bit microcontroller core: the address latch pulse (ALE, active high) and the program-store read strobe (PSEN, active low). It runs from the oscillator clock. It divides each machine cycle of twelve oscillator periods into six states of two phases, and places the strobe edges at fixed phases inside that cycle.

The core supplies two flags for each machine cycle: whether code comes from external program memory and whether the cycle accesses external data memory. The block samples both flags at the start of the cycle. It omits one ALE pulse and both PSEN assertions in data cycles.

The block also holds a software ALE-disable bit. While that bit is active, ALE stops pulsing and a weak pullup keeps the pin high. The disable is overridden during table or external-data instructions, in idle, in power-down and in emulation mode. It also has no effect while code is fetched externally. The power mode sets steady strobe levels, and the timing counter freezes while the oscillator is stopped.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale`=0, `psen_n`=1 and `ale_pullup_en`=0. The timing counter rests at tick 0 (state 1, phase 1; tick = 2*(state-1) + (phase-1)). The first rising clock edge with `rst_n` high moves it to tick 1, and the counter then advances one tick per clock, wrapping from 11 to 0.
- R2: In run mode (`pwr_mode`=0) with the disable inactive, `ale` is 1 exactly during ticks 1 and 7 (S1P2 and S4P2), which is two pulses per machine cycle, one every six clocks.
- R3: In a cycle whose sampled data flag is 1, the tick-1 ALE pulse is omitted and the tick-7 pulse is kept.
- R4: In run mode, in a cycle with the sampled fetch flag 1 and data flag 0, `psen_n` is 0 exactly during ticks 4, 5, 10 and 11. With the fetch flag 0, `psen_n` stays 1.
- R5: In a cycle whose sampled data flag is 1, `psen_n` stays 1 for the whole cycle, even when the fetch flag is 1.
- R6: `ext_fetch` and `ext_data` are sampled only at the clock edge that enters tick 0. A change of either flag later in the cycle does not affect that cycle.
- R7: A write (`sfr_we`=1) to `sfr_addr`=8'h8E loads `sfr_wbit` into the ALE-disable bit. While the bit is 1 in run mode with no override and no external fetch, `ale`=0 and `ale_pullup_en`=1. Writes to any other address leave the bit unchanged. Writing 0 restores normal pulsing.
- R8: While `xmem_insn`=1 or `emu_mode`=1, an active disable bit has no effect: ALE pulses as in R2 and R3, and `ale_pullup_en`=0.
- R9: In a cycle with the sampled fetch flag 1, an active disable bit has no effect: ALE pulses as in R2 and R3, and `ale_pullup_en`=0.
- R10: In idle (`pwr_mode`=1), `ale`=1, `psen_n`=1 and `ale_pullup_en`=0 on every clock, whatever the disable bit. The counter keeps running.
- R11: In power-down (`pwr_mode`=2 or 3), `ale`=0, `psen_n`=0 and `ale_pullup_en`=0, and the counter holds its tick. After the return to run mode the counter continues from the held tick.
- R12: Reset clears the ALE-disable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock, one tick per period |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_mode | input | 2 | 0 run, 1 idle, 2 or 3 power-down |
| emu_mode | input | 1 | Emulation mode active |
| xmem_insn | input | 1 | A table-read or external-data instruction is executing |
| ext_fetch | input | 1 | The coming machine cycle fetches from external program memory |
| ext_data | input | 1 | The coming machine cycle accesses external data memory |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wbit | input | 1 | Written value of the ALE-disable bit |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program store strobe, active low |
| ale_pullup_en | output | 1 | Enables the weak pullup on the ALE pin |

## Verification
A slipped or frozen tick counter shifts every ALE and PSEN edge. The shift appears at the ports within one machine cycle as pulses at ticks other than 1 and 7, or as PSEN windows other than 4-5 and 10-11. A wrongly sampled cycle flag shows in the same cycle as a missing or extra tick-1 pulse, or as a PSEN window in the wrong cycle. A disable bit in the wrong state shows on the next clock as ALE held low with the pullup on, or the reverse. A counter that runs in power-down shows at the first tick after wake-up as an ALE pulse at the wrong time.

// File: rtl/bsg_pkg.sv
// Package: shared types and timing constants for the bus strobe generator.
// Assumes two phases per state and an even state count.
package bsg_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2,
        PM_HALT = 2'd3
    } pwr_mode_e;

    typedef struct packed {
        logic fetch;
        logic data;
    } cyc_flags_t;

endpackage

// File: rtl/bsg_timing.sv
// Module: bsg_timing
// Counts oscillator ticks within a machine cycle and latches the per-cycle
// fetch and data flags at the edge that enters tick 0. Exposes both the
// current and the next-state values so outputs can be registered in step.
// Assumes: advance is low only while the oscillator is considered stopped.
module bsg_timing #(
    parameter int TICKS = 12,
    parameter int TW    = $clog2(TICKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic                ext_fetch,
    input  logic                ext_data,
    output logic [TW-1:0]       tick_q,
    output logic [TW-1:0]       tick_d,
    output bsg_pkg::cyc_flags_t flags_q,
    output bsg_pkg::cyc_flags_t flags_d
);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    logic boundary;

    // Next tick and next cycle flags.
    always_comb begin
        boundary = advance && (tick_q == LAST);
        if (!advance)
            tick_d = tick_q;
        else if (tick_q == LAST)
            tick_d = '0;
        else
            tick_d = tick_q + 1'b1;
        flags_d = flags_q;
        if (boundary) begin
            flags_d.fetch = ext_fetch;
            flags_d.data  = ext_data;
        end
    end

    // Counter and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q  <= '0;
            flags_q <= '0;
        end else begin
            tick_q  <= tick_d;
            flags_q <= flags_d;
        end
    end
endmodule

// File: rtl/bsg_ale_ctrl.sv
// Module: bsg_ale_ctrl
// Holds the software ALE-disable bit, written through a single-bit register
// port decoded at AUX_ADDR. Reset clears the bit.
// Assumes: one write per clock at most.
module bsg_ale_ctrl #(
    parameter int         AW       = 8,
    parameter logic [7:0] AUX_ADDR = 8'h8E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sfr_we,
    input  logic [AW-1:0] sfr_addr,
    input  logic          sfr_wbit,
    output logic          dis_q,
    output logic          dis_d
);
    localparam logic [AW-1:0] HIT = AW'(AUX_ADDR);

    // Next value of the disable bit.
    always_comb begin
        dis_d = dis_q;
        if (sfr_we && (sfr_addr == HIT))
            dis_d = sfr_wbit;
    end

    // Disable bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dis_q <= 1'b0;
        else
            dis_q <= dis_d;
    end
endmodule

// File: rtl/bsg_strobe_out.sv
// Module: bsg_strobe_out
// Decodes the next tick, cycle flags, disable bit and power mode into
// registered ALE, PSEN and pullup outputs. Because the decode uses next-state
// values, each output register changes at the same edge as the counter.
// Assumes: N_STATES even, PSEN windows start at the first phase of state
// N_STATES/2 and state N_STATES and last one state each.
module bsg_strobe_out #(
    parameter int N_STATES = 6,
    parameter int N_PHASES = 2,
    parameter int TICKS    = N_STATES * N_PHASES,
    parameter int TW       = $clog2(TICKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TW-1:0]       tick_d,
    input  bsg_pkg::cyc_flags_t flags_d,
    input  logic                dis_d,
    input  logic [1:0]          pwr_mode,
    input  logic                xmem_insn,
    input  logic                emu_mode,
    output logic                ale,
    output logic                psen_n,
    output logic                ale_pullup_en
);
    import bsg_pkg::*;

    localparam int HALF = N_STATES / 2;
    localparam logic [TW-1:0] ALE_A = TW'(N_PHASES - 1);
    localparam logic [TW-1:0] ALE_B = TW'(HALF * N_PHASES + N_PHASES - 1);
    localparam int NWIN = 2;

    logic [NWIN-1:0] win_hit;
    logic            override, suppress, in_ale, in_psen;
    logic            ale_d, psen_n_d, pu_d;
    pwr_mode_e       pm;

    // One comparator pair per PSEN window.
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam int START_STATE = (w == 0) ? (HALF - 1) : (N_STATES - 1);
        localparam logic [TW-1:0] W_LO = TW'(START_STATE * N_PHASES);
        localparam logic [TW-1:0] W_HI = TW'(START_STATE * N_PHASES + N_PHASES - 1);
        assign win_hit[w] = (tick_d >= W_LO) && (tick_d <= W_HI);
    end

    // Next output levels from mode, flags and tick.
    always_comb begin
        pm       = pwr_mode_e'(pwr_mode);
        override = xmem_insn || emu_mode || (pm != PM_RUN);
        suppress = dis_d && !override && !flags_d.fetch;
        in_ale   = ((tick_d == ALE_A) && !flags_d.data) || (tick_d == ALE_B);
        in_psen  = flags_d.fetch && !flags_d.data && (|win_hit);
        case (pm)
            PM_RUN: begin
                ale_d    = in_ale && !suppress;
                psen_n_d = !in_psen;
                pu_d     = suppress;
            end
            PM_IDLE: begin
                ale_d    = 1'b1;
                psen_n_d = 1'b1;
                pu_d     = 1'b0;
            end
            default: begin
                ale_d    = 1'b0;
                psen_n_d = 1'b0;
                pu_d     = 1'b0;
            end
        endcase
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale           <= 1'b0;
            psen_n        <= 1'b1;
            ale_pullup_en <= 1'b0;
        end else begin
            ale           <= ale_d;
            psen_n        <= psen_n_d;
            ale_pullup_en <= pu_d;
        end
    end
endmodule

// File: rtl/bus_strobe_gen.sv
// Module: bus_strobe_gen (top)
// External bus strobe generator: tick counter, ALE-disable bit and registered
// strobe decode. Assumes one oscillator period per clock and cycle flags held
// valid by the core at the last tick of the preceding cycle.
module bus_strobe_gen #(
    parameter int         N_STATES = 6,
    parameter int         N_PHASES = 2,
    parameter int         AW       = 8,
    parameter logic [7:0] AUX_ADDR = 8'h8E
) (
    input  logic          clk_osc,
    input  logic          rst_n,
    input  logic [1:0]    pwr_mode,
    input  logic          emu_mode,
    input  logic          xmem_insn,
    input  logic          ext_fetch,
    input  logic          ext_data,
    input  logic          sfr_we,
    input  logic [AW-1:0] sfr_addr,
    input  logic          sfr_wbit,
    output logic          ale,
    output logic          psen_n,
    output logic          ale_pullup_en
);
    import bsg_pkg::*;

    localparam int TICKS = N_STATES * N_PHASES;
    localparam int TW    = $clog2(TICKS);

    logic [TW-1:0] tick_q, tick_d;
    cyc_flags_t    flags_q, flags_d;
    logic          dis_q, dis_d;
    logic          advance;

    // The counter stops only in power-down.
    assign advance = (pwr_mode == PM_RUN) || (pwr_mode == PM_IDLE);

    bsg_timing #(.TICKS(TICKS), .TW(TW)) u_timing (
        .clk(clk_osc), .rst_n(rst_n), .advance(advance),
        .ext_fetch(ext_fetch), .ext_data(ext_data),
        .tick_q(tick_q), .tick_d(tick_d),
        .flags_q(flags_q), .flags_d(flags_d)
    );

    bsg_ale_ctrl #(.AW(AW), .AUX_ADDR(AUX_ADDR)) u_ctrl (
        .clk(clk_osc), .rst_n(rst_n), .sfr_we(sfr_we),
        .sfr_addr(sfr_addr), .sfr_wbit(sfr_wbit),
        .dis_q(dis_q), .dis_d(dis_d)
    );

    bsg_strobe_out #(.N_STATES(N_STATES), .N_PHASES(N_PHASES),
                     .TICKS(TICKS), .TW(TW)) u_out (
        .clk(clk_osc), .rst_n(rst_n), .tick_d(tick_d), .flags_d(flags_d),
        .dis_d(dis_d), .pwr_mode(pwr_mode), .xmem_insn(xmem_insn),
        .emu_mode(emu_mode), .ale(ale), .psen_n(psen_n),
        .ale_pullup_en(ale_pullup_en)
    );
endmodule

// File: rtl/bsg_checker.sv
// Module: bsg_checker
// Clocked properties on the strobe generator, bound into the top module.
// Assumes the inputs are driven from time zero.
module bsg_checker #(
    parameter int TICKS = 12,
    parameter int TW    = $clog2(TICKS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    pwr_mode,
    input logic          xmem_insn,
    input logic          emu_mode,
    input logic [TW-1:0] tick,
    input logic          cyc_fetch,
    input logic          cyc_data,
    input logic          dis_bit,
    input logic          ale,
    input logic          psen_n,
    input logic          ale_pullup_en
);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    // R1: the counter never leaves its cycle range
    assert_tick_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= LAST);

    // R4: internal code never drives PSEN in run mode
    assert_psen_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_mode) == 2'd0 && !cyc_fetch) |-> psen_n);

    // R5: data cycles suppress PSEN
    assert_psen_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_mode) == 2'd0 && cyc_data) |-> psen_n);

    // R7: pullup only while ALE is not driven and the bit is set
    assert_pullup_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ale_pullup_en |-> (!ale && dis_bit));

    // R8: an override removes the pullup
    assert_override_pu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xmem_insn || emu_mode) |-> !ale_pullup_en);

    // R10: idle holds both strobes high
    assert_idle_levels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_mode) == 2'd1) |-> (ale && psen_n && !ale_pullup_en));

    // R11: power-down freezes the counter
    assert_down_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pwr_mode[1])) |-> $stable(tick));
endmodule

bind bus_strobe_gen bsg_checker #(.TICKS(TICKS), .TW(TW)) u_chk (
    .clk(clk_osc), .rst_n(rst_n), .pwr_mode(pwr_mode),
    .xmem_insn(xmem_insn), .emu_mode(emu_mode), .tick(tick_q),
    .cyc_fetch(flags_q.fetch), .cyc_data(flags_q.data), .dis_bit(dis_q),
    .ale(ale), .psen_n(psen_n), .ale_pullup_en(ale_pullup_en)
);

// File: tb/bus_strobe_gen_bench.sv
// Directed bench for bus_strobe_gen: one task per scenario.
module bus_strobe_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_mode = 2'd0;
    logic       emu_mode = 1'b0, xmem_insn = 1'b0;
    logic       ext_fetch = 1'b0, ext_data = 1'b0;
    logic       sfr_we = 1'b0, sfr_wbit = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       ale, psen_n, ale_pullup_en;

    int n_cmp = 0, n_bad = 0;
    int b_tick = 0;
    bit done = 0;

    localparam logic [11:0] ALE_NORM = 12'h082;
    localparam logic [11:0] ALE_DATA = 12'h080;
    localparam logic [11:0] PSEN_WIN = 12'hC30;

    always #2.5 clk = ~clk;

    bus_strobe_gen u_bus_strobe_gen (
        .clk_osc(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .emu_mode(emu_mode),
        .xmem_insn(xmem_insn), .ext_fetch(ext_fetch), .ext_data(ext_data),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wbit(sfr_wbit),
        .ale(ale), .psen_n(psen_n), .ale_pullup_en(ale_pullup_en)
    );

    // Expected tick per R1 and R11.
    always @(posedge clk) begin
        if (!rst_n)
            b_tick <= 0;
        else if (!pwr_mode[1])
            b_tick <= (b_tick == 11) ? 0 : b_tick + 1;
    end

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One machine cycle: set flags before its first edge, record 12 ticks.
    task automatic run_mc(input logic f, input logic d, input logic mid_en,
                          input logic mid_v, output logic [11:0] ap,
                          output logic [11:0] pp, output logic [11:0] up);
        while (b_tick != 11) @(negedge clk);
        ext_fetch = f;
        ext_data  = d;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ap[i] = ale;
            pp[i] = !psen_n;
            up[i] = ale_pullup_en;
            if (mid_en && i == 2) begin
                ext_fetch = mid_v;
                ext_data  = mid_v;
            end
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic v);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wbit = v;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [11:0] ap, pp, up;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset ale", {11'd0, ale}, 12'd0);
        chk("R1 reset psen_n", {11'd0, psen_n}, 12'd1);
        chk("R1 reset pullup", {11'd0, ale_pullup_en}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first tick ale", {11'd0, ale}, 12'd1);
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R2 internal ale", ap, ALE_NORM);
        chk("R4 internal psen", pp, 12'h000);
    endtask

    task automatic t_fetch_data;
        logic [11:0] ap, pp, up;
        run_mc(1, 0, 0, 0, ap, pp, up);
        chk("R2 fetch ale", ap, ALE_NORM);
        chk("R4 fetch psen", pp, PSEN_WIN);
        run_mc(1, 1, 0, 0, ap, pp, up);
        chk("R3 data ale", ap, ALE_DATA);
        chk("R5 data psen", pp, 12'h000);
        run_mc(0, 0, 1, 1, ap, pp, up);
        chk("R6 late flags ale", ap, ALE_NORM);
        chk("R6 late flags psen", pp, 12'h000);
        run_mc(0, 0, 0, 0, ap, pp, up);
    endtask

    task automatic t_disable;
        logic [11:0] ap, pp, up;
        write_reg(8'h8F, 1'b1);
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R7 other address ale", ap, ALE_NORM);
        write_reg(8'h8E, 1'b1);
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R7 disabled ale", ap, 12'h000);
        chk("R7 disabled pullup", up, 12'hFFF);
        xmem_insn = 1'b1;
        run_mc(0, 1, 0, 0, ap, pp, up);
        chk("R8 xmem ale", ap, ALE_DATA);
        chk("R8 xmem pullup", up, 12'h000);
        xmem_insn = 1'b0; emu_mode = 1'b1;
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R8 emu ale", ap, ALE_NORM);
        chk("R8 emu pullup", up, 12'h000);
        emu_mode = 1'b0;
        run_mc(1, 0, 0, 0, ap, pp, up);
        chk("R9 fetch ale", ap, ALE_NORM);
        chk("R9 fetch psen", pp, PSEN_WIN);
        chk("R9 fetch pullup", up, 12'h000);
        pwr_mode = 2'd1;
        run_mc(1, 0, 0, 0, ap, pp, up);
        chk("R10 idle ale", ap, 12'hFFF);
        chk("R10 idle psen", pp, 12'h000);
        chk("R10 idle pullup", up, 12'h000);
        pwr_mode = 2'd0;
        run_mc(0, 0, 0, 0, ap, pp, up);
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R7 still disabled after idle", up, 12'hFFF);
        write_reg(8'h8E, 1'b0);
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R7 cleared ale", ap, ALE_NORM);
        chk("R7 cleared pullup", up, 12'h000);
    endtask

    task automatic t_power_down;
        while (b_tick != 0) @(negedge clk);
        pwr_mode = 2'd2;
        repeat (5) @(negedge clk);
        chk("R11 down levels", {10'd0, ale, psen_n}, 12'd0);
        pwr_mode = 2'd3;
        repeat (3) @(negedge clk);
        chk("R11 halt levels", {10'd0, ale, ale_pullup_en}, 12'd0);
        pwr_mode = 2'd0;
        @(negedge clk);
        chk("R11 resume at tick 1", {11'd0, ale}, 12'd1);
        repeat (6) @(negedge clk);
        chk("R11 resume at tick 7", {11'd0, ale}, 12'd1);
    endtask

    task automatic t_reset_clears;
        logic [11:0] ap, pp, up;
        write_reg(8'h8E, 1'b1);
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R12 set before reset", up, 12'hFFF);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_mc(0, 0, 0, 0, ap, pp, up);
        chk("R12 ale after reset", ap, ALE_NORM);
        chk("R12 pullup after reset", up, 12'h000);
    endtask

    initial begin
        t_reset();
        t_fetch_data();
        t_disable();
        t_power_down();
        t_reset_clears();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule